// File: doc/BRIEF.md
# Vector Instruction Prefix Encoder

This block turns a set of already-decoded instruction fields into the compact vector-extension prefix that comes in front of an opcode. The fields are the operating mode (64-bit or narrower), the four register-extension bits W, R, X and B, an opcode map number, a 4-bit extra register specifier, the vector length and a selector that stands in for one of the legacy refining prefixes. From these it picks a short two-byte form or a long three-byte form, packs the fields into the prefix bytes and hands the bytes out one at a time on a valid/ready byte stream.

A single `start_i` strobe captures all fields. The block holds them until the last byte has been accepted, then pulses `done_o`. If the field combination cannot be encoded, no byte is sent. Instead, `err_o` pulses for one cycle and the block stays idle.

Top module: `pfx_encoder`

## Requirements
- R1: The long form (first byte 0xC4, three bytes in total) is chosen when X=1, B=1, W=1 or the map number is 0, 2 or 3. Otherwise the short form is used (first byte 0xC5, two bytes in total).
- R2: Bit 7 of the second byte carries R inverted, in both forms.
- R3: In the long form, bit 6 of the second byte is X inverted, bit 5 is B inverted, and bits 4:0 are the map number, zero-extended.
- R4: In the long form, bit 7 of the third byte is W. The short form carries no W bit.
- R5: Bits 6:3 of the final byte are the register specifier, unchanged in 64-bit mode. Outside 64-bit mode, bit 6 is forced to 1 and bits 5:3 pass through.
- R6: Bit 2 of the final byte is the length (0 for 128, 1 for 256). Bits 1:0 are the refining selector: 00 none, 01 for 66, 10 for F3, 11 for F2.
- R7: Three cases are errors: R=1 outside 64-bit mode; X=1 or B=1 in the long form outside 64-bit mode; a map number above 3. On an error no byte is sent, and `err_o` is high for exactly the one cycle after the start strobe.
- R8: The first byte is valid in the cycle after the start strobe. While `byte_valid_o` is high and `byte_ready_i` is low, `byte_o` and `last_o` hold their values.
- R9: `last_o` is high exactly on the final byte. `done_o` is high for exactly the one cycle after that byte is accepted.
- R10: The fields are captured at the start strobe. Later changes to the inputs, and start strobes that arrive while bytes are still being sent, have no effect on the bytes.
- R11: Synchronous active-high reset returns the block to idle with `byte_valid_o`, `done_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture fields and begin encoding |
| long_mode_i | input | 1 | 1 = 64-bit operating mode |
| ext_w_i | input | 1 | W extension bit |
| ext_r_i | input | 1 | R extension bit |
| ext_x_i | input | 1 | X extension bit |
| ext_b_i | input | 1 | B extension bit |
| map_i | input | 3 | Opcode map number |
| vreg_i | input | 4 | Extra register specifier |
| len256_i | input | 1 | 1 = 256-bit vector length |
| simd_sel_i | input | 2 | Refining selector: 0 none, 1 = 66, 2 = F3, 3 = F2 |
| byte_o | output | 8 | Prefix byte |
| byte_valid_o | output | 1 | Byte on `byte_o` is valid |
| byte_ready_i | input | 1 | Downstream accepts the byte |
| last_o | output | 1 | Current byte is the final prefix byte |
| done_o | output | 1 | One-cycle pulse after the final byte is accepted |
| err_o | output | 1 | One-cycle pulse for an unencodable field set |

## Verification
The bench sweeps every combination of mode, W, R, X, B and all eight map codes, including the illegal ones, across every length and selector value, while the register specifier cycles through all sixteen values. A design that chose the form wrongly would send the wrong escape byte and byte count. A design that missed an inversion would flip bits in the second byte. A design that let the 64-bit case through outside 64-bit mode would leave the top specifier bit clear. A design that missed one of the three error rules would send bytes where it should only pulse `err_o`.

Backpressure stalls come from a repeating pattern. During each stall the bench raises a new start strobe and drives the inverted field set. This catches any design that drops a byte, changes it under stall, or recaptures its fields in mid-send.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int MAP_W       = 3;
    localparam int MAP_FIELD_W = 5;
    localparam int MAX_MAP     = 3;
    localparam int VREG_W      = 4;
    localparam int SEL_W       = 2;
    localparam int BYTE_W      = 8;
    localparam int MAX_BYTES   = 3;
    localparam int IDX_W       = $clog2(MAX_BYTES);
    localparam int TAIL_W      = VREG_W + 1 + SEL_W;

    localparam logic [BYTE_W-1:0] ESC_LONG  = 8'hC4;
    localparam logic [BYTE_W-1:0] ESC_SHORT = 8'hC5;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE = 2'd0,
        SEL_66   = 2'd1,
        SEL_F3   = 2'd2,
        SEL_F2   = 2'd3
    } simd_sel_e;

    typedef struct packed {
        logic              m64;
        logic              w;
        logic              r;
        logic              x;
        logic              b;
        logic [MAP_W-1:0]  map;
        logic [VREG_W-1:0] vreg;
        logic              len256;
        simd_sel_e         sel;
    } pfx_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_DONE
    } pfx_state_e;

    function automatic logic needs_long(pfx_fields_t f);
        return f.x | f.b | f.w | (f.map != MAP_W'(1));
    endfunction

    function automatic logic [VREG_W-1:0] eff_vreg(pfx_fields_t f);
        return f.m64 ? f.vreg : {1'b1, f.vreg[VREG_W-2:0]};
    endfunction

    function automatic logic [TAIL_W-1:0] tail_bits(pfx_fields_t f);
        return {eff_vreg(f), f.len256, f.sel};
    endfunction

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_pkg::*;
(
    input  pfx_fields_t fields_i,
    output logic        bad_o
);
    logic map_bad;
    logic r_bad;
    logic xb_bad;

    always_comb begin
        map_bad = (fields_i.map > MAP_W'(MAX_MAP));
        r_bad   = !fields_i.m64 && fields_i.r;
        xb_bad  = !fields_i.m64 && needs_long(fields_i) && (fields_i.x || fields_i.b);
        bad_o   = map_bad || r_bad || xb_bad;
    end
endmodule

// File: rtl/pfx_packer.sv
module pfx_packer
    import pfx_pkg::*;
(
    input  pfx_fields_t                          fields_i,
    output logic [MAX_BYTES-1:0][BYTE_W-1:0]     bytes_o,
    output logic [IDX_W-1:0]                     last_idx_o
);
    logic long_form;

    always_comb begin
        long_form = needs_long(fields_i);
        bytes_o   = '0;
        if (long_form) begin
            bytes_o[0] = ESC_LONG;
            bytes_o[1] = {~fields_i.r, ~fields_i.x, ~fields_i.b,
                          MAP_FIELD_W'(fields_i.map)};
            bytes_o[2] = {fields_i.w, tail_bits(fields_i)};
            last_idx_o = IDX_W'(MAX_BYTES - 1);
        end else begin
            bytes_o[0] = ESC_SHORT;
            bytes_o[1] = {~fields_i.r, tail_bits(fields_i)};
            last_idx_o = IDX_W'(MAX_BYTES - 2);
        end
    end
endmodule

// File: rtl/pfx_stream.sv
module pfx_stream
    import pfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             bad_i,
    input  logic [IDX_W-1:0] last_idx_i,
    input  logic             ready_i,
    output logic             capture_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             done_o,
    output logic             err_o
);
    pfx_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             err_q;

    assign capture_o = (state_q == ST_IDLE) && start_i;
    assign valid_o   = (state_q == ST_SEND);
    assign last_o    = valid_o && (idx_q == last_idx_i);
    assign done_o    = (state_q == ST_DONE);
    assign err_o     = err_q;
    assign idx_o     = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= capture_o && bad_i;
            case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (capture_o && !bad_i) state_q <= ST_SEND;
                end
                ST_SEND: begin
                    if (ready_i) begin
                        if (last_o) state_q <= ST_DONE;
                        else        idx_q   <= idx_q + IDX_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pfx_encoder.sv
module pfx_encoder
    import pfx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  long_mode_i,
    input  logic                  ext_w_i,
    input  logic                  ext_r_i,
    input  logic                  ext_x_i,
    input  logic                  ext_b_i,
    input  logic [MAP_W-1:0]      map_i,
    input  logic [VREG_W-1:0]     vreg_i,
    input  logic                  len256_i,
    input  logic [SEL_W-1:0]      simd_sel_i,
    output logic [BYTE_W-1:0]     byte_o,
    output logic                  byte_valid_o,
    input  logic                  byte_ready_i,
    output logic                  last_o,
    output logic                  done_o,
    output logic                  err_o
);
    pfx_fields_t                      live_f;
    pfx_fields_t                      held_q;
    logic                             bad;
    logic                             capture;
    logic [MAX_BYTES-1:0][BYTE_W-1:0] bytes;
    logic [IDX_W-1:0]                 last_idx;
    logic [IDX_W-1:0]                 idx;

    always_comb begin
        live_f.m64    = long_mode_i;
        live_f.w      = ext_w_i;
        live_f.r      = ext_r_i;
        live_f.x      = ext_x_i;
        live_f.b      = ext_b_i;
        live_f.map    = map_i;
        live_f.vreg   = vreg_i;
        live_f.len256 = len256_i;
        live_f.sel    = simd_sel_e'(simd_sel_i);
    end

    always_ff @(posedge clk) begin
        if (rst)          held_q <= '0;
        else if (capture) held_q <= live_f;
    end

    pfx_classify i_classify (
        .fields_i (live_f),
        .bad_o    (bad)
    );

    pfx_packer i_packer (
        .fields_i   (held_q),
        .bytes_o    (bytes),
        .last_idx_o (last_idx)
    );

    pfx_stream i_stream (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .bad_i      (bad),
        .last_idx_i (last_idx),
        .ready_i    (byte_ready_i),
        .capture_o  (capture),
        .idx_o      (idx),
        .valid_o    (byte_valid_o),
        .last_o     (last_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    assign byte_o = byte_valid_o ? bytes[idx] : '0;
endmodule

// File: rtl/pfx_encoder_chk.sv
module pfx_encoder_chk
    import pfx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [BYTE_W-1:0] byte_o,
    input logic              byte_valid_o,
    input logic              byte_ready_i,
    input logic              last_o,
    input logic              done_o,
    input logic              err_o
);
    assert_escape_first_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_valid_o) |-> (byte_o == ESC_LONG || byte_o == ESC_SHORT));

    assert_err_silent_R7: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !byte_valid_o);

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_o) && $stable(last_o)));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        (byte_valid_o && byte_ready_i && last_o) |=> (done_o && !byte_valid_o));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!byte_valid_o && !done_o && !err_o));
endmodule

bind pfx_encoder pfx_encoder_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .byte_ready_i (byte_ready_i),
    .last_o       (last_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/test_pfx_encoder.sv
module test_pfx_encoder;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic       long_mode_i, ext_w_i, ext_r_i, ext_x_i, ext_b_i;
    logic [2:0] map_i;
    logic [3:0] vreg_i;
    logic       len256_i;
    logic [1:0] simd_sel_i;
    logic [7:0] byte_o;
    logic       byte_valid_o;
    logic       byte_ready_i;
    logic       last_o, done_o, err_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    pfx_encoder i_pfx_encoder (
        .clk(clk), .rst(rst), .start_i(start_i),
        .long_mode_i(long_mode_i), .ext_w_i(ext_w_i), .ext_r_i(ext_r_i),
        .ext_x_i(ext_x_i), .ext_b_i(ext_b_i), .map_i(map_i), .vreg_i(vreg_i),
        .len256_i(len256_i), .simd_sel_i(simd_sel_i),
        .byte_o(byte_o), .byte_valid_o(byte_valid_o), .byte_ready_i(byte_ready_i),
        .last_o(last_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [16:0] v);
        {long_mode_i, ext_w_i, ext_r_i, ext_x_i, ext_b_i, map_i, vreg_i, len256_i, simd_sel_i} = v[15:0];
    endtask

    task automatic run_one(input bit m64, input bit w, input bit r, input bit x, input bit b,
                           input int map, input int vreg, input bit len, input int sel);
        bit       lng, bad;
        int       n;
        int       got;
        logic [7:0] exp [3];
        logic [3:0] ev;
        logic [6:0] tail;
        logic [15:0] fv;
        logic [7:0] stall_byte;
        bit         stalled;
        lng  = x | b | w | (map != 1);
        bad  = (!m64 && r) || (!m64 && lng && (x | b)) || (map > 3);
        ev   = m64 ? 4'(vreg) : {1'b1, 3'(vreg)};
        tail = {ev, len, 2'(sel)};
        n    = lng ? 3 : 2;
        if (lng) begin
            exp[0] = 8'hC4;
            exp[1] = {~r, ~x, ~b, 5'(map)};
            exp[2] = {w, tail};
        end else begin
            exp[0] = 8'hC5;
            exp[1] = {~r, tail};
            exp[2] = 8'h00;
        end
        fv = {m64, w, r, x, b, 3'(map), 4'(vreg), len, 2'(sel)};
        drive({1'b0, fv});
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        drive({1'b0, ~fv});
        if (bad) begin
            check(err_o && !byte_valid_o, "R7 err pulse", {err_o, byte_valid_o}, 2);
            @(negedge clk);
            check(!err_o && !byte_valid_o, "R7 err one cycle", {err_o, byte_valid_o}, 0);
            return;
        end
        check(!err_o && byte_valid_o, "R8 first byte timing", {err_o, byte_valid_o}, 1);
        got     = 0;
        stalled = 1'b0;
        for (int k = 0; k < 40 && got < n; k++) begin
            if (stalled)
                check(byte_valid_o && byte_o == stall_byte, "R8 stall hold", byte_o, stall_byte);
            byte_ready_i = ((cyc % 3) != 1);
            stalled = 1'b0;
            if (byte_valid_o && byte_ready_i) begin
                start_i = 1'b0;
                if (got == 0)
                    check(byte_o == exp[0], "R1 escape", byte_o, exp[0]);
                if (got == 1)
                    check(byte_o[7] == ~r, "R2 inverted R", byte_o[7], ~r);
                if (lng && got == 1)
                    check(byte_o[6:0] == exp[1][6:0], "R3 X B map", byte_o[6:0], exp[1][6:0]);
                if (lng && got == 2)
                    check(byte_o[7] == w, "R4 W bit", byte_o[7], w);
                if (got == n - 1) begin
                    check(byte_o[6:3] == ev, "R5 specifier", byte_o[6:3], ev);
                    check(byte_o[2:0] == tail[2:0], "R6 length and selector", byte_o[2:0], tail[2:0]);
                end
                check(last_o == (got == n - 1), "R9 last flag", last_o, (got == n - 1));
                if (got >= 1)
                    check(byte_o == exp[got], "R10 captured fields", byte_o, exp[got]);
                got++;
            end else if (byte_valid_o) begin
                stalled    = 1'b1;
                stall_byte = byte_o;
                start_i    = 1'b1;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(got == n, "R1 byte count", got, n);
        check(done_o && !byte_valid_o, "R9 done pulse", {done_o, byte_valid_o}, 2);
        @(negedge clk);
        check(!done_o && !byte_valid_o, "R9 done one cycle", {done_o, byte_valid_o}, 0);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        rst = 1'b1; start_i = 1'b0; byte_ready_i = 1'b1;
        drive('0);
        repeat (3) @(negedge clk);
        check(!byte_valid_o && !done_o && !err_o, "R11 reset idle",
              {byte_valid_o, done_o, err_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!byte_valid_o && !done_o && !err_o, "R11 idle after reset",
              {byte_valid_o, done_o, err_o}, 0);
        for (int c = 0; c < 256; c++)
            for (int ls = 0; ls < 8; ls++)
                run_one(c[7], c[6], c[5], c[4], c[3], c[2:0], (c + ls) % 16, ls[2], ls[1:0]);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule